// File: doc/BRIEF.md
# Z80 Bus Cycle Stepper

This block sits beside a Z80 CPU and decides when the processor may finish its current bus cycle. It does this through the CPU's active-low wait input. In stepping mode it holds every memory, I/O or opcode-fetch cycle until the operator asks for one more cycle. In free-run mode it never holds the CPU. A hold-to-run button gives free running for as long as it is pressed.

The same block also drives the CPU reset line from a latching switch and a momentary button. The reset line is open-drain: the block only ever pulls it low. Every mechanical input first passes through a two-flop synchronizer and then a counter debouncer, all clocked by the CPU clock.

Top module: `bus_cycle_stepper`

## Requirements
- R1: With the debounced mode switch off (`free_run_sw` = 0), `wait_n` goes low as soon as a bus strobe is active and no step has been granted for it.
- R2: A bus strobe is active when `rfsh_n` is 1 and at least one of `mreq_n`, `iorq_n` or `m1_n` is 0. While `rfsh_n` is 0, `wait_n` stays high.
- R3: A debounced rising edge of the step request, seen while a strobe is stalled, raises `wait_n` on the next rising clock edge. `wait_n` then stays high until that strobe ends.
- R4: Once the strobe ends, the next strobe is stalled again. A step request that stays high does not release a second cycle. A step edge seen while no strobe is active is dropped.
- R5: The step request is the OR of the debounced `step_btn` and `step_sw`, so either source can step.
- R6: While the debounced `run_btn` is 1, `wait_n` is high. After it is released, a strobe that is still active is stalled again.
- R7: With the debounced `free_run_sw` = 1, `wait_n` is 1 for every bus input pattern.
- R8: `cpu_reset_pull` is 1 (pull the reset line low) while the debounced `reset_sw` or `reset_btn` is 1, and 0 otherwise. The block has no way to drive the line high.
- R9: While the CPU reset is requested, `wait_n` is 1 and any granted step is cleared. A strobe that is still active after the reset ends is therefore stalled.
- R10: Each mechanical input is synchronized by `SYNC_STAGES` flops. The debounced level changes only after the synchronized input has differed from it on `DEBOUNCE_CYCLES` consecutive edges, so a pulse one cycle shorter than that is ignored.
- R11: After `rst_n` is released, with all buttons and switches at 0 and the bus idle, `wait_n` = 1 and `cpu_reset_pull` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| mreq_n | input | 1 | Memory request strobe, active low |
| iorq_n | input | 1 | I/O request strobe, active low |
| m1_n | input | 1 | Opcode fetch indicator, active low |
| rfsh_n | input | 1 | Refresh indicator, active low |
| free_run_sw | input | 1 | Mode switch: 1 = free run, 0 = stepping |
| step_btn | input | 1 | Next-cycle push-button, 1 = pressed |
| step_sw | input | 1 | Switch wired in parallel with the next-cycle button |
| run_btn | input | 1 | Hold-to-run push-button, 1 = pressed |
| reset_btn | input | 1 | CPU reset push-button, 1 = pressed |
| reset_sw | input | 1 | Latching CPU reset switch, 1 = reset on |
| wait_n | output | 1 | Active-low wait to the CPU |
| cpu_reset_pull | output | 1 | 1 = pull the open-drain CPU reset line low |

## Verification
The bench builds the block with `DEBOUNCE_CYCLES` = 4 and `SYNC_STAGES` = 2. This makes every button action settle within about a dozen clock periods. It also places the filter boundary where the bench can test it directly: a 3-cycle pulse must be rejected and a 4-cycle pulse accepted. With such short settling times, the bench can sweep all sixteen patterns of the four bus inputs in stepping, free-run and reset conditions. The remaining time goes to the step handshake sequences: release, re-arm, held button, early press, parallel switch, hold-to-run, and a reset that cancels a grant.

// File: rtl/stepper_pkg.sv
`timescale 1ns/1ps
package stepper_pkg;
  // Index of each mechanical input inside the conditioned vector
  localparam int unsigned CH_FREE    = 0;
  localparam int unsigned CH_STEPBTN = 1;
  localparam int unsigned CH_STEPSW  = 2;
  localparam int unsigned CH_RUNBTN  = 3;
  localparam int unsigned CH_RSTBTN  = 4;
  localparam int unsigned CH_RSTSW   = 5;
  localparam int unsigned NUM_CH     = 6;

  // A cycle worth stalling: any request strobe outside refresh
  function automatic logic bus_strobe(input logic mreq_n, input logic iorq_n,
                                      input logic m1_n, input logic rfsh_n);
    return rfsh_n & (~mreq_n | ~iorq_n | ~m1_n);
  endfunction
endpackage

// File: rtl/stepper_debounce.sv
`timescale 1ns/1ps
module stepper_debounce #(
  parameter int unsigned DB_CYCLES   = 40000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic level_o
);
  localparam int unsigned CW = $clog2(DB_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(DB_CYCLES - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   synced;
  logic [CW-1:0]          cnt_q;
  logic                   level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
  end

  assign synced = sync_q[SYNC_STAGES-1];

  // Level follows the input only after DB_CYCLES consecutive disagreements
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      level_q <= 1'b0;
    end else if (synced == level_q) begin
      cnt_q <= '0;
    end else if (cnt_q == LAST) begin
      cnt_q   <= '0;
      level_q <= synced;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign level_o = level_q;
endmodule

// File: rtl/stepper_inputs.sv
`timescale 1ns/1ps
module stepper_inputs #(
  parameter int unsigned NUM_CH      = 6,
  parameter int unsigned DB_CYCLES   = 40000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] raw_i,
  output logic [NUM_CH-1:0] level_o
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    stepper_debounce #(
      .DB_CYCLES  (DB_CYCLES),
      .SYNC_STAGES(SYNC_STAGES)
    ) u_db (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw_i  (raw_i[g]),
      .level_o(level_o[g])
    );
  end
endmodule

// File: rtl/stepper_wait_ctrl.sv
`timescale 1ns/1ps
module stepper_wait_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_i,
  input  logic free_i,
  input  logic reset_i,
  input  logic step_level_i,
  output logic wait_n_o,
  output logic step_pulse_o
);
  logic step_prev_q;
  logic granted_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step_prev_q <= 1'b0;
    else        step_prev_q <= step_level_i;
  end

  assign step_pulse_o = step_level_i & ~step_prev_q;

  // A grant lives only as long as the strobe it was given to
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           granted_q <= 1'b0;
    else if (reset_i || free_i || !strobe_i) granted_q <= 1'b0;
    else if (step_pulse_o)                granted_q <= 1'b1;
  end

  // Combinational from the strobe so the stall is in place before the CPU samples it
  assign wait_n_o = ~(strobe_i & ~free_i & ~reset_i & ~granted_q);
endmodule

// File: rtl/bus_cycle_stepper.sv
`timescale 1ns/1ps
module bus_cycle_stepper
  import stepper_pkg::*;
#(
  parameter int unsigned DEBOUNCE_CYCLES = 40000,
  parameter int unsigned SYNC_STAGES     = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mreq_n,
  input  logic iorq_n,
  input  logic m1_n,
  input  logic rfsh_n,
  input  logic free_run_sw,
  input  logic step_btn,
  input  logic step_sw,
  input  logic run_btn,
  input  logic reset_btn,
  input  logic reset_sw,
  output logic wait_n,
  output logic cpu_reset_pull
);
  logic [NUM_CH-1:0] raw;
  logic [NUM_CH-1:0] lvl;
  logic stall_strobe;
  logic free_run;
  logic reset_req;
  logic step_level;
  logic step_pulse;

  always_comb begin
    raw             = '0;
    raw[CH_FREE]    = free_run_sw;
    raw[CH_STEPBTN] = step_btn;
    raw[CH_STEPSW]  = step_sw;
    raw[CH_RUNBTN]  = run_btn;
    raw[CH_RSTBTN]  = reset_btn;
    raw[CH_RSTSW]   = reset_sw;
  end

  stepper_inputs #(
    .NUM_CH     (NUM_CH),
    .DB_CYCLES  (DEBOUNCE_CYCLES),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_inputs (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw_i  (raw),
    .level_o(lvl)
  );

  assign stall_strobe = bus_strobe(mreq_n, iorq_n, m1_n, rfsh_n);
  assign free_run     = lvl[CH_FREE] | lvl[CH_RUNBTN];
  assign reset_req    = lvl[CH_RSTBTN] | lvl[CH_RSTSW];
  assign step_level   = lvl[CH_STEPBTN] | lvl[CH_STEPSW];

  stepper_wait_ctrl u_wait (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobe_i    (stall_strobe),
    .free_i      (free_run),
    .reset_i     (reset_req),
    .step_level_i(step_level),
    .wait_n_o    (wait_n),
    .step_pulse_o(step_pulse)
  );

  assign cpu_reset_pull = reset_req;
endmodule

// File: rtl/bus_cycle_stepper_chk.sv
`timescale 1ns/1ps
module bus_cycle_stepper_chk (
  input logic clk,
  input logic rst_n,
  input logic wait_n,
  input logic cpu_reset_pull,
  input logic stall_strobe,
  input logic free_run,
  input logic reset_req,
  input logic step_pulse
);
  AST_IDLE_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    !stall_strobe |-> wait_n); // R2

  AST_FREE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    free_run |-> wait_n); // R7

  AST_RESET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_reset_pull |-> wait_n); // R9

  AST_STEP_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_strobe && $past(stall_strobe) && !free_run && !reset_req &&
     $past(!free_run && !reset_req) && wait_n && !$past(wait_n))
    |-> $past(step_pulse)); // R3

  AST_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(stall_strobe) && !free_run && !reset_req) |-> !wait_n); // R4
endmodule

bind bus_cycle_stepper bus_cycle_stepper_chk chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .wait_n        (wait_n),
  .cpu_reset_pull(cpu_reset_pull),
  .stall_strobe  (stall_strobe),
  .free_run      (free_run),
  .reset_req     (reset_req),
  .step_pulse    (step_pulse)
);

// File: tb/bus_cycle_stepper_tb_top.sv
`timescale 1ns/1ps
module bus_cycle_stepper_tb_top;
  localparam int unsigned DB   = 4;
  localparam int unsigned SETL = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mreq_n = 1'b1, iorq_n = 1'b1, m1_n = 1'b1, rfsh_n = 1'b1;
  logic free_run_sw = 1'b0, step_btn = 1'b0, step_sw = 1'b0;
  logic run_btn = 1'b0, reset_btn = 1'b0, reset_sw = 1'b0;
  logic wait_n, cpu_reset_pull;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  bus_cycle_stepper #(.DEBOUNCE_CYCLES(DB), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .mreq_n(mreq_n), .iorq_n(iorq_n), .m1_n(m1_n),
    .rfsh_n(rfsh_n), .free_run_sw(free_run_sw), .step_btn(step_btn),
    .step_sw(step_sw), .run_btn(run_btn), .reset_btn(reset_btn),
    .reset_sw(reset_sw), .wait_n(wait_n), .cpu_reset_pull(cpu_reset_pull)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic bus(input logic [3:0] v);
    {mreq_n, iorq_n, m1_n, rfsh_n} = v;
    #1;
  endtask

  // Sweep all bus patterns; forced = 1 means wait must stay high
  task automatic sweep(input string req, input logic forced);
    for (int v = 0; v < 16; v++) begin
      logic [3:0] b;
      logic strobe;
      b = 4'(v);
      bus(b);
      strobe = b[0] & (~b[3] | ~b[2] | ~b[1]);
      chk(forced ? req : (b[0] ? "R1" : "R2"), wait_n, forced ? 1'b1 : ~strobe);
      tick(1);
    end
    bus(4'b1111);
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(2);
    chk("R11", wait_n, 1'b1);
    chk("R11", cpu_reset_pull, 1'b0);

    sweep("R1", 1'b0);

    free_run_sw = 1'b1; tick(SETL);
    sweep("R7", 1'b1);
    free_run_sw = 1'b0; tick(SETL);

    reset_sw = 1'b1; tick(SETL);
    chk("R8", cpu_reset_pull, 1'b1);
    sweep("R9", 1'b1);
    reset_sw = 1'b0; tick(SETL);
    chk("R8", cpu_reset_pull, 1'b0);

    // Single step: stall, release, hold, re-arm
    bus(4'b0111); tick(5);
    chk("R1", wait_n, 1'b0);
    step_btn = 1'b1; tick(SETL);
    chk("R3", wait_n, 1'b1);
    step_btn = 1'b0; tick(SETL);
    chk("R3", wait_n, 1'b1);
    bus(4'b1111); tick(2);
    bus(4'b0111);
    chk("R4", wait_n, 1'b0);

    // Held button does not release a second cycle
    step_btn = 1'b1; tick(SETL);
    chk("R3", wait_n, 1'b1);
    bus(4'b1111); tick(2);
    bus(4'b1011);
    chk("R4", wait_n, 1'b0);
    step_btn = 1'b0; tick(SETL);
    chk("R4", wait_n, 1'b0);

    // Press with no strobe is dropped
    bus(4'b1111);
    step_btn = 1'b1; tick(SETL);
    step_btn = 1'b0; tick(SETL);
    bus(4'b1101);
    chk("R4", wait_n, 1'b0);

    // Parallel switch steps too
    step_sw = 1'b1; tick(SETL);
    chk("R5", wait_n, 1'b1);
    step_sw = 1'b0; tick(SETL);
    bus(4'b1111); tick(2);
    bus(4'b0111); tick(1);
    chk("R5", wait_n, 1'b0);

    // Debounce boundary: DB-1 cycles rejected, DB cycles accepted
    step_btn = 1'b1; tick(DB - 1);
    step_btn = 1'b0; tick(SETL);
    chk("R10", wait_n, 1'b0);
    step_btn = 1'b1; tick(DB);
    step_btn = 1'b0; tick(SETL);
    chk("R10", wait_n, 1'b1);
    bus(4'b1111); tick(2);
    bus(4'b0111); tick(1);
    chk("R4", wait_n, 1'b0);

    // Hold-to-run
    run_btn = 1'b1; tick(SETL);
    chk("R6", wait_n, 1'b1);
    run_btn = 1'b0; tick(SETL);
    chk("R6", wait_n, 1'b0);

    // Reset cancels a grant
    step_btn = 1'b1; tick(SETL);
    step_btn = 1'b0; tick(SETL);
    chk("R3", wait_n, 1'b1);
    reset_btn = 1'b1; tick(SETL);
    chk("R8", cpu_reset_pull, 1'b1);
    chk("R9", wait_n, 1'b1);
    reset_btn = 1'b0; tick(SETL);
    chk("R8", cpu_reset_pull, 1'b0);
    chk("R9", wait_n, 1'b0);
    bus(4'b1111); tick(2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 8);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule